// File: doc/BRIEF.md
# Planar Video Pixel Serializer

This block sits between display-memory fetch and the attribute stage of a video pipeline. Once per character-width fetch it takes one byte from each of four memory planes, holds them in shift registers, and then hands out one 4-bit colour nibble per pixel clock. A 2-bit format selection decides how bits of the four plane bytes turn into pixels. The choices are independent per-plane bit lanes for ordinary 16-colour graphics, 2-bit packed pixels for a 320-by-200 four-colour compatibility layout, and whole 8-bit pixels sent as two nibbles each for a 256-colour mode.

A load strobe copies all plane bytes and the format selection into the block in a single cycle. After that, each asserted pixel enable moves the stream forward by one output nibble. Bits shifted in behind the loaded data are zero. In the 8-bit format a strobe marks the nibble that carries the upper half of a pixel, so the next stage can pair it with the following lower half.

Top module: `planar_pixel_serializer`

## Requirements
- R1: While reset is active and after its release, `pix_o` is 0, `hi_nib_o` is 0, and the held format is planar (0).
- R2: A cycle with `load_i` high copies all four plane bytes and `fmt_i` into the block, and the first pixel of the new data is on `pix_o` in the next cycle. If `pix_en_i` is high in the same cycle, the load wins and no shift happens. Outside a load, `fmt_i` has no effect.
- R3: In a cycle with neither `load_i` nor `pix_en_i`, `pix_o` and `hi_nib_o` keep their values.
- R4: Format 0 (planar): `pix_o[p]` is bit 7-k of plane p's byte at pixel k (k = 0..7), MSB first. After eight pixels, zeros follow.
- R5: Format 1 (packed): pixels 0-3 take `pix_o[1:0]` from the bit pairs of plane 0's byte and `pix_o[3:2]` from the pairs of plane 2's byte, highest pair first. Pixels 4-7 do the same with planes 1 and 3. In each pair the upper bit goes to the higher output bit. After eight pixels, zeros follow.
- R6: Format 2 (wide): nibble k (k = 0..7) is bits 7:4 of plane k/2's byte when k is even and bits 3:0 when k is odd, so planes 0 to 3 each give one 8-bit pixel in order. After eight nibbles, zeros follow.
- R7: Format 3 behaves exactly like format 2.
- R8: `hi_nib_o` is 1 only in formats 2 and 3. It is 1 on nibble 0 after a load and then toggles on each pixel enable, so it marks the even (upper-half) nibbles. In formats 0 and 1 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Copy plane bytes and format into the shift registers |
| pix_en_i | input | 1 | Pixel clock enable; advance one output nibble |
| fmt_i | input | 2 | Format selection: 0 planar, 1 packed 2-bit, 2/3 wide 8-bit |
| plane_data_i | input | 32 | Plane bytes; plane p at bits 8p+7:8p |
| pix_o | output | 4 | Current pixel nibble |
| hi_nib_o | output | 1 | Upper-half marker for wide-format nibbles |

## Verification
The assertions assume that `load_i` and `pix_en_i` are plain synchronous levels that are stable around the clock edge. They make no assumption on how often loads come: a load may arrive in the middle of a stream, with or without a pixel enable. The stimulus drives all inputs a quarter period after each rising edge and returns the strobes to zero in every cycle it does not use. It deliberately includes a load together with a pixel enable, changes of `fmt_i` between loads, and enables that run past the eighth pixel.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

   typedef enum logic [1:0] {
      FMT_PLANAR   = 2'd0,
      FMT_PACKED   = 2'd1,
      FMT_WIDE     = 2'd2,
      FMT_WIDE_ALT = 2'd3
   } pxs_fmt_e;

   // Both upper codes select whole 8-bit pixels
   function automatic logic fmt_is_wide(input pxs_fmt_e f);
      return f[1];
   endfunction

endpackage

// File: rtl/pxs_shift_bank.sv
module pxs_shift_bank
   import pxs_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic                          adv_i,
   input  pxs_fmt_e                      fmt_i,
   input  logic [PLANES*BYTE_W-1:0]      data_i,
   output logic [PLANES-1:0][BYTE_W-1:0] sr_o
);

   localparam int PAIR_W = 2;
   localparam int NIB_W  = 4;

   logic [PLANES-1:0][BYTE_W-1:0] sr_q;
   logic [PLANES-1:0][BYTE_W-1:0] nxt_planar;
   logic [PLANES-1:0][BYTE_W-1:0] nxt_packed;
   logic [PLANES-1:0][BYTE_W-1:0] nxt_wide;
   logic [PLANES-1:0][BYTE_W-1:0] nxt_sel;

   generate
      if (PLANES != 4) begin : g_bad_planes
         $error("pxs_shift_bank: PLANES must be 4");
      end
      if (BYTE_W % NIB_W != 0 || BYTE_W < 2*NIB_W) begin : g_bad_width
         $error("pxs_shift_bank: BYTE_W must be a multiple of 4, at least 8");
      end

      for (genvar p = 0; p < PLANES; p++) begin : g_plane
         // independent lanes, one bit per pixel
         assign nxt_planar[p] = {sr_q[p][BYTE_W-2:0], 1'b0};

         // packed: even plane drains first, refilled from its odd neighbour
         if (p % 2 == 0) begin : g_pk_head
            assign nxt_packed[p] = {sr_q[p][BYTE_W-PAIR_W-1:0],
                                    sr_q[p+1][BYTE_W-1:BYTE_W-PAIR_W]};
         end else begin : g_pk_tail
            assign nxt_packed[p] = {sr_q[p][BYTE_W-PAIR_W-1:0], {PAIR_W{1'b0}}};
         end

         // wide: one chain through all planes, a nibble per step
         if (p < PLANES-1) begin : g_wd_link
            assign nxt_wide[p] = {sr_q[p][BYTE_W-NIB_W-1:0],
                                  sr_q[p+1][BYTE_W-1:BYTE_W-NIB_W]};
         end else begin : g_wd_end
            assign nxt_wide[p] = {sr_q[p][BYTE_W-NIB_W-1:0], {NIB_W{1'b0}}};
         end
      end
   endgenerate

   always_comb begin
      unique case (fmt_i)
         FMT_PLANAR:             nxt_sel = nxt_planar;
         FMT_PACKED:             nxt_sel = nxt_packed;
         FMT_WIDE, FMT_WIDE_ALT: nxt_sel = nxt_wide;
         default:                nxt_sel = nxt_planar;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= '0;
      else if (load_i) sr_q <= data_i;
      else if (adv_i)  sr_q <= nxt_sel;
   end

   assign sr_o = sr_q;

   // R2: a load lands every plane byte in one cycle
   p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sr_q == $past(data_i)));

   // R3: no strobe, no movement
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(sr_q));

   // R4: planar step leaves a zero in every lane's low bit
   p_planar_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && fmt_i == FMT_PLANAR) |=>
         (sr_q[0][0] == 1'b0 && sr_q[PLANES-1][0] == 1'b0));

   // R5: packed step moves the odd plane's top pair into the even plane
   p_packed_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && fmt_i == FMT_PACKED) |=>
         (sr_q[0][PAIR_W-1:0] == $past(sr_q[1][BYTE_W-1:BYTE_W-PAIR_W])));

   // R6: wide step feeds plane 0 from plane 1's top nibble
   p_wide_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && fmt_is_wide(fmt_i)) |=>
         (sr_q[0][NIB_W-1:0] == $past(sr_q[1][BYTE_W-1:BYTE_W-NIB_W])));

endmodule

// File: rtl/pxs_pix_select.sv
module pxs_pix_select
   import pxs_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8
) (
   input  pxs_fmt_e                      fmt_i,
   input  logic [PLANES-1:0][BYTE_W-1:0] sr_i,
   output logic [PLANES-1:0]             pix_o
);

   localparam int PAIR_W = 2;
   localparam int NIB_W  = 4;

   logic [PLANES-1:0] pix_planar;
   logic [PLANES-1:0] pix_packed;
   logic [PLANES-1:0] pix_wide;

   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_lane
         assign pix_planar[p] = sr_i[p][BYTE_W-1];
      end
      for (genvar h = 0; h < PLANES/PAIR_W; h++) begin : g_pair
         // colour bits 1:0 from the plane 0/1 chain, 3:2 from plane 2/3
         assign pix_packed[h*PAIR_W +: PAIR_W] =
            sr_i[h*PAIR_W][BYTE_W-1:BYTE_W-PAIR_W];
      end
   endgenerate

   assign pix_wide = sr_i[0][BYTE_W-1:BYTE_W-NIB_W];

   always_comb begin
      unique case (fmt_i)
         FMT_PLANAR:             pix_o = pix_planar;
         FMT_PACKED:             pix_o = pix_packed;
         FMT_WIDE, FMT_WIDE_ALT: pix_o = pix_wide;
         default:                pix_o = pix_planar;
      endcase
   end

endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer
   import pxs_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic                     pix_en_i,
   input  logic [1:0]               fmt_i,
   input  logic [PLANES*BYTE_W-1:0] plane_data_i,
   output logic [PLANES-1:0]        pix_o,
   output logic                     hi_nib_o
);

   localparam int PIX_W = PLANES;

   pxs_fmt_e                      fmt_q;
   logic                          phase_q;
   logic [PLANES-1:0][BYTE_W-1:0] sr;
   logic [PIX_W-1:0]              pix;

   generate
      if (PIX_W != 4) begin : g_bad_pix
         $error("planar_pixel_serializer: output nibble must be 4 bits");
      end
   endgenerate

   // format is held with the data it describes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fmt_q <= FMT_PLANAR;
      else if (load_i) fmt_q <= pxs_fmt_e'(fmt_i);
   end

   // half-pixel phase for the wide format
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                phase_q <= 1'b0;
      else if (load_i)                           phase_q <= 1'b0;
      else if (pix_en_i && fmt_is_wide(fmt_q))   phase_q <= ~phase_q;
   end

   pxs_shift_bank #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .adv_i  (pix_en_i),
      .fmt_i  (fmt_q),
      .data_i (plane_data_i),
      .sr_o   (sr)
   );

   pxs_pix_select #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_sel (
      .fmt_i (fmt_q),
      .sr_i  (sr),
      .pix_o (pix)
   );

   assign pix_o    = pix;
   assign hi_nib_o = fmt_is_wide(fmt_q) & ~phase_q;

   // R8: the marker only exists in the wide formats
   p_hi_only_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_nib_o |-> fmt_q[1]);

   // R8: the marker alternates with every wide-format step
   p_hi_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en_i && !load_i && fmt_q[1]) |=> (hi_nib_o != $past(hi_nib_o)));

   // R2: a load starts on an upper half when the new format is wide
   p_load_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (hi_nib_o == $past(fmt_i[1])));

   // R3: outputs frozen without strobes
   p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !pix_en_i) |=> ($stable(pix_o) && $stable(hi_nib_o)));

endmodule

// File: tb/planar_pixel_serializer_tb.sv
module planar_pixel_serializer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic        pix_en_i = 1'b0;
   logic [1:0]  fmt_i = 2'd0;
   logic [31:0] plane_data_i = '0;
   logic [3:0]  pix_o;
   logic        hi_nib_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   planar_pixel_serializer u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .pix_en_i     (pix_en_i),
      .fmt_i        (fmt_i),
      .plane_data_i (plane_data_i),
      .pix_o        (pix_o),
      .hi_nib_o     (hi_nib_o)
   );

   // {format, plane3, plane2, plane1, plane0}
   localparam logic [33:0] VEC [8] = '{
      {2'd0, 32'hA5_3C_F0_81},
      {2'd0, 32'h00_FF_55_AA},
      {2'd1, 32'hE4_1B_C6_39},
      {2'd1, 32'h0F_F0_96_69},
      {2'd2, 32'h12_34_56_78},
      {2'd2, 32'hFE_DC_BA_98},
      {2'd3, 32'hC3_5A_A5_3C},
      {2'd3, 32'h01_80_7E_E7}
   };

   function automatic logic [3:0] exp_pix(logic [1:0] f, logic [31:0] d, int k);
      logic [3:0] r;
      r = '0;
      if (k < 8) begin
         if (f == 2'd0) begin
            for (int i = 0; i < 4; i++) r[i] = d[8*i + 7 - k];
         end else if (f == 2'd1) begin
            if (k < 4) begin
               r[1:0] = d[6 - 2*k +: 2];
               r[3:2] = d[16 + 6 - 2*k +: 2];
            end else begin
               r[1:0] = d[8 + 6 - 2*(k-4) +: 2];
               r[3:2] = d[24 + 6 - 2*(k-4) +: 2];
            end
         end else begin
            r = (k % 2 == 0) ? d[8*(k/2) + 4 +: 4] : d[8*(k/2) +: 4];
         end
      end
      return r;
   endfunction

   task automatic check(string req, logic [3:0] ep, logic eh);
      n_run++;
      if (pix_o !== ep || hi_nib_o !== eh) begin
         n_fail++;
         $display("FAIL %s: pix=%h hi=%b expected pix=%h hi=%b",
                  req, pix_o, hi_nib_o, ep, eh);
      end
   endtask

   // drive for one rising edge; sampling point is 5 ns after it
   task automatic cyc(logic l, logic e, logic [1:0] f, logic [31:0] d);
      load_i = l; pix_en_i = e; fmt_i = f; plane_data_i = d;
      @(posedge clk);
      #5;
      load_i = 1'b0; pix_en_i = 1'b0;
   endtask

   function automatic string req_of(logic [1:0] f);
      case (f)
         2'd0: return "R4";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #5;
      check("R1 in reset", 4'h0, 1'b0);
      rst_n = 1'b1;
      cyc(1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
      check("R1 after reset", 4'h0, 1'b0);

      // table walk: load, then step past the end of the data
      for (int v = 0; v < 8; v++) begin
         logic [1:0]  f;
         logic [31:0] d;
         f = VEC[v][33:32];
         d = VEC[v][31:0];
         cyc(1'b1, 1'b0, f, d);
         for (int k = 0; k < 10; k++) begin
            check(req_of(f), exp_pix(f, d, k), f[1] && (k % 2 == 0));
            check("R8", exp_pix(f, d, k), f[1] && (k % 2 == 0));
            cyc(1'b0, 1'b1, 2'd0, 32'h0);
         end
      end

      // R3: hold with no strobes, fmt_i and data wiggling (R2: ignored)
      cyc(1'b1, 1'b0, 2'd0, 32'h5A_C3_0F_96);
      cyc(1'b0, 1'b1, 2'd0, 32'h0);
      cyc(1'b0, 1'b0, 2'd2, 32'hFFFF_FFFF);
      check("R3 hold", exp_pix(2'd0, 32'h5A_C3_0F_96, 1), 1'b0);
      cyc(1'b0, 1'b0, 2'd3, 32'h1234_5678);
      check("R3 hold", exp_pix(2'd0, 32'h5A_C3_0F_96, 1), 1'b0);
      // R2: format change without load stays planar on the next step
      cyc(1'b0, 1'b1, 2'd2, 32'h0);
      check("R2 fmt ignored", exp_pix(2'd0, 32'h5A_C3_0F_96, 2), 1'b0);

      // R2/R8: reload in mid-stream with pixel enable, load wins
      cyc(1'b1, 1'b0, 2'd2, 32'h11_22_33_44);
      cyc(1'b0, 1'b1, 2'd0, 32'h0);
      cyc(1'b0, 1'b1, 2'd0, 32'h0);
      cyc(1'b0, 1'b1, 2'd0, 32'h0);
      check("R8 odd nibble", exp_pix(2'd2, 32'h11_22_33_44, 3), 1'b0);
      cyc(1'b1, 1'b1, 2'd3, 32'h9A_BC_DE_F0);
      check("R2 load wins", exp_pix(2'd3, 32'h9A_BC_DE_F0, 0), 1'b1);
      cyc(1'b0, 1'b1, 2'd0, 32'h0);
      check("R7 step", exp_pix(2'd3, 32'h9A_BC_DE_F0, 1), 1'b0);

      // R2/R8: reload into packed drops the marker
      cyc(1'b1, 1'b1, 2'd1, 32'h33_CC_0F_F0);
      check("R8 packed no marker", exp_pix(2'd1, 32'h33_CC_0F_F0, 0), 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule